// File: doc/BRIEF.md
# Burst Transfer Counter and DMA Requester

This block steers the master side of a multi-byte serial bus burst. Software or a sequencer programs a burst length and pulses a start strobe; the length is copied into a down-counter, which drops by one for every byte the byte engine reports as finished. When the count runs out, the burst ends and a completion status bit is set. A not-acknowledge from the far side ends the burst early. Whether a STOP is issued then depends on where the NACK came in and on the STOP request flag. The counter is frozen at that moment, so the number of bytes already moved can be worked out from what is left.

While a burst runs and the DMA channel is enabled, the block raises four request lines. For each of the transmit and receive directions there is a single-byte request and a multi-byte request. These are derived from the FIFO fill levels, the trigger levels and the remaining count. Completion pulses from the DMA engine, one per direction, set their own status bits. All status bits stay set until a write-one-to-clear, and a mask turns them into masked status.

The byte-level bus engine, the FIFOs and the DMA controller sit outside. They are seen only through strobes and fill levels.

Top module: `burst_xfer_ctrl`

## Requirements
- R1: After reset, burstActive, burstCount, issueStop, all four request lines, irqRaw and irqMasked are all zero.
- R2: A burstStart pulse while idle copies burstLen into burstCount on the next clock edge, and burstActive rises then if burstLen is non-zero. burstStart is ignored while a burst is active.
- R3: Each byteDone pulse during an active burst decrements burstCount by one. byteDone while idle leaves burstCount unchanged.
- R4: The byteDone that takes burstCount from 1 to 0 ends the burst and sets irqRaw bit 0 (burst done). A start with burstLen of zero sets bit 0 immediately and never becomes active.
- R5: nackData during an active burst with stopReq high ends the burst, pulses issueStop for one cycle, sets irqRaw bit 1 (NACK) and leaves burstCount unchanged.
- R6: nackData during an active burst with stopReq low ends the burst and sets irqRaw bit 1, with no issueStop pulse and burstCount unchanged.
- R7: nackAddr during an active burst always pulses issueStop, ends the burst and sets irqRaw bit 1, whatever stopReq is. NACK strobes take priority over byteDone in the same cycle, and NACK strobes while idle are ignored.
- R8: rxSreq is high when rxFill is non-zero, and txSreq is high when txFill is below the FIFO depth (8).
- R9: rxBreq is high when rxFill is above rxTrig. txBreq is high when burstCount is below 4 and txFill is below txTrig.
- R10: All four request lines are low whenever no burst is active or dmaEn is low.
- R11: A dmaDoneTx pulse sets irqRaw bit 2 and a dmaDoneRx pulse sets irqRaw bit 3, whether or not a burst is active.
- R12: irqRaw bits hold until a clock with the matching irqClr bit high. A set and a clear in the same cycle leave the bit set. irqMasked equals irqRaw AND irqMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstLen | input | 8 | Programmed burst length in bytes |
| burstStart | input | 1 | Start-of-burst strobe |
| stopReq | input | 1 | STOP request flag from control |
| byteDone | input | 1 | Byte acknowledged or received |
| nackData | input | 1 | NACK on a data byte |
| nackAddr | input | 1 | NACK on the address phase |
| dmaEn | input | 1 | DMA channel enable |
| txFill | input | 4 | Transmit FIFO fill level |
| rxFill | input | 4 | Receive FIFO fill level |
| txTrig | input | 4 | Transmit trigger level |
| rxTrig | input | 4 | Receive trigger level |
| dmaDoneTx | input | 1 | Transmit DMA completion pulse |
| dmaDoneRx | input | 1 | Receive DMA completion pulse |
| irqMask | input | 4 | Interrupt mask |
| irqClr | input | 4 | Write-one-to-clear strobes |
| burstActive | output | 1 | Burst in progress |
| burstCount | output | 8 | Remaining byte count |
| issueStop | output | 1 | One-cycle STOP command |
| txSreq | output | 1 | Transmit single request |
| txBreq | output | 1 | Transmit burst request |
| rxSreq | output | 1 | Receive single request |
| rxBreq | output | 1 | Receive burst request |
| irqRaw | output | 4 | Raw status: 0 done, 1 NACK, 2 TX DMA, 3 RX DMA |
| irqMasked | output | 4 | Masked status |

## Verification
The bench targets the three NACK outcomes. A design that mixes them up issues a STOP on a plain data NACK, misses the STOP on an address NACK, or keeps counting after a NACK, which corrupts the bytes-moved figure. It drives a NACK in the same cycle as a byte completion, where wrong priority decrements the count one time too many. It starts zero-length bursts, which a careless counter would wrap to its maximum. It sweeps fill levels across the trigger levels and the remaining count across 4 to catch off-by-one comparisons. It also collides a set with a clear on the same status bit, where a wrong priority loses the event.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int IRQ_W     = 4;
  localparam int IRQ_DONE  = 0;
  localparam int IRQ_NACK  = 1;
  localparam int IRQ_DMATX = 2;
  localparam int IRQ_DMARX = 3;

  typedef struct packed {
    logic load;
    logic dec;
    logic setDone;
    logic setNack;
    logic stopNow;
  } ctlStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstStart,
  input  logic       byteDone,
  input  logic       nackData,
  input  logic       nackAddr,
  input  logic       stopReq,
  input  logic       lenIsZero,
  input  logic       countIsOne,
  output logic       active,
  output ctlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (burstStart) begin
          strobe.load = 1'b1;
          if (lenIsZero) strobe.setDone = 1'b1;
          else           nextState      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (nackAddr) begin
          strobe.setNack = 1'b1;
          strobe.stopNow = 1'b1;
          nextState      = ST_IDLE;
        end else if (nackData) begin
          strobe.setNack = 1'b1;
          strobe.stopNow = stopReq;
          nextState      = ST_IDLE;
        end else if (byteDone) begin
          strobe.dec = 1'b1;
          if (countIsOne) begin
            strobe.setDone = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign active = (state == ST_RUN);

  // R2
  start_activates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && burstStart && !lenIsZero) |=> active);

  // R7
  nack_ends_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && (nackData || nackAddr)) |=> !active);
endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int BREQ_REMAIN = 4,
  localparam int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              active,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic              dmaEn,
  input  logic [FILL_W-1:0] txFill,
  input  logic [FILL_W-1:0] rxFill,
  input  logic [FILL_W-1:0] txTrig,
  input  logic [FILL_W-1:0] rxTrig,
  input  logic              dmaDoneTx,
  input  logic              dmaDoneRx,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic [IRQ_W-1:0]  irqClr,
  output logic [CNT_W-1:0]  count,
  output logic              lenIsZero,
  output logic              countIsOne,
  output logic              issueStop,
  output logic              txSreq,
  output logic              txBreq,
  output logic              rxSreq,
  output logic              rxBreq,
  output logic [IRQ_W-1:0]  irqRaw,
  output logic [IRQ_W-1:0]  irqMasked
);
  localparam logic [FILL_W-1:0] FULL_LVL   = FILL_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0]  REMAIN_LIM = CNT_W'(BREQ_REMAIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= burstLen;
    else if (strobe.dec)  count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) issueStop <= 1'b0;
    else       issueStop <= strobe.stopNow;
  end

  assign lenIsZero  = (burstLen == '0);
  assign countIsOne = (count == CNT_W'(1));

  logic reqGate;
  assign reqGate = active && dmaEn;
  assign rxSreq  = reqGate && (rxFill != '0);
  assign txSreq  = reqGate && (txFill < FULL_LVL);
  assign rxBreq  = reqGate && (rxFill > rxTrig);
  assign txBreq  = reqGate && (count < REMAIN_LIM) && (txFill < txTrig);

  logic [IRQ_W-1:0] irqSet;
  always_comb begin
    irqSet            = '0;
    irqSet[IRQ_DONE]  = strobe.setDone;
    irqSet[IRQ_NACK]  = strobe.setNack;
    irqSet[IRQ_DMATX] = dmaDoneTx;
    irqSet[IRQ_DMARX] = dmaDoneRx;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          irqRaw[i] <= 1'b0;
      else if (irqSet[i]) irqRaw[i] <= 1'b1;
      else if (irqClr[i]) irqRaw[i] <= 1'b0;
    end
  end

  assign irqMasked = irqRaw & irqMask;

  // R5
  nack_count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setNack |=> (count == $past(count)));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDoneTx && irqClr[IRQ_DMATX]) |=> irqRaw[IRQ_DMATX]);
endmodule

// File: rtl/burst_xfer_ctrl.sv
module burst_xfer_ctrl
  import burst_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int BREQ_REMAIN = 4,
  localparam int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic              burstStart,
  input  logic              stopReq,
  input  logic              byteDone,
  input  logic              nackData,
  input  logic              nackAddr,
  input  logic              dmaEn,
  input  logic [FILL_W-1:0] txFill,
  input  logic [FILL_W-1:0] rxFill,
  input  logic [FILL_W-1:0] txTrig,
  input  logic [FILL_W-1:0] rxTrig,
  input  logic              dmaDoneTx,
  input  logic              dmaDoneRx,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic [IRQ_W-1:0]  irqClr,
  output logic              burstActive,
  output logic [CNT_W-1:0]  burstCount,
  output logic              issueStop,
  output logic              txSreq,
  output logic              txBreq,
  output logic              rxSreq,
  output logic              rxBreq,
  output logic [IRQ_W-1:0]  irqRaw,
  output logic [IRQ_W-1:0]  irqMasked
);
  ctlStrobe_t strobe;
  logic lenIsZero, countIsOne;

  burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .byteDone(byteDone),
    .nackData(nackData), .nackAddr(nackAddr), .stopReq(stopReq),
    .lenIsZero(lenIsZero), .countIsOne(countIsOne),
    .active(burstActive), .strobe(strobe)
  );

  burst_dpath #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .BREQ_REMAIN(BREQ_REMAIN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(burstActive),
    .burstLen(burstLen), .dmaEn(dmaEn), .txFill(txFill), .rxFill(rxFill),
    .txTrig(txTrig), .rxTrig(rxTrig), .dmaDoneTx(dmaDoneTx), .dmaDoneRx(dmaDoneRx),
    .irqMask(irqMask), .irqClr(irqClr), .count(burstCount),
    .lenIsZero(lenIsZero), .countIsOne(countIsOne), .issueStop(issueStop),
    .txSreq(txSreq), .txBreq(txBreq), .rxSreq(rxSreq), .rxBreq(rxBreq),
    .irqRaw(irqRaw), .irqMasked(irqMasked)
  );

  // R7
  addr_nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && nackAddr) |=> issueStop);

  // R6
  data_nack_nostop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && nackData && !nackAddr && !stopReq) |=> (!issueStop && !burstActive));

  // R3
  idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && !burstStart) |=> $stable(burstCount));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(burstActive && dmaEn) |-> !(txSreq || txBreq || rxSreq || rxBreq));

  // R11
  dma_rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaDoneRx |=> irqRaw[IRQ_DMARX]);

  // R12
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqRaw[IRQ_NACK] && !irqClr[IRQ_NACK]) |=> irqRaw[IRQ_NACK]);
endmodule

// File: tb/sim_burst_xfer_ctrl.sv
module sim_burst_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] burstLen = '0;
  logic burstStart = 0, stopReq = 0, byteDone = 0, nackData = 0, nackAddr = 0, dmaEn = 0;
  logic [3:0] txFill = '0, rxFill = '0, txTrig = '0, rxTrig = '0;
  logic dmaDoneTx = 0, dmaDoneRx = 0;
  logic [3:0] irqMask = '0, irqClr = '0;
  logic burstActive, issueStop, txSreq, txBreq, rxSreq, rxBreq;
  logic [7:0] burstCount;
  logic [3:0] irqRaw, irqMasked;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_xfer_ctrl u0 (.*);

  int checks = 0, fails = 0;
  string curReq = "R1";

  int mActive = 0, mCount = 0, mStop = 0;
  int mRaw = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive = 0; mCount = 0; mStop = 0; mRaw = 0;
    end else begin
      int sets;
      sets = 0;
      mStop = 0;
      if (mActive != 0) begin
        if (nackAddr) begin
          mActive = 0; mStop = 1; sets |= 2;
        end else if (nackData) begin
          mActive = 0; mStop = stopReq ? 1 : 0; sets |= 2;
        end else if (byteDone) begin
          mCount = mCount - 1;
          if (mCount == 0) begin mActive = 0; sets |= 1; end
        end
      end else if (burstStart) begin
        mCount = burstLen;
        if (burstLen == 0) sets |= 1;
        else mActive = 1;
      end
      if (dmaDoneTx) sets |= 4;
      if (dmaDoneRx) sets |= 8;
      mRaw = (mRaw & ~int'(irqClr)) | sets;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", curReq, nm, act, exp);
    end
  endtask

  task automatic compareAll();
    int g;
    g = (mActive != 0 && dmaEn) ? 1 : 0;
    chk("burstActive", burstActive, mActive);
    chk("burstCount", burstCount, mCount);
    chk("issueStop", issueStop, mStop);
    chk("rxSreq", rxSreq, g & (rxFill != 0));
    chk("txSreq", txSreq, g & (txFill < DEPTH));
    chk("rxBreq", rxBreq, g & (rxFill > rxTrig));
    chk("txBreq", txBreq, g & (mCount < 4) & (txFill < txTrig));
    chk("irqRaw", irqRaw, mRaw);
    chk("irqMasked", irqMasked, mRaw & int'(irqMask));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    compareAll();
    burstStart = 0; byteDone = 0; nackData = 0; nackAddr = 0;
    dmaDoneTx = 0; dmaDoneRx = 0; irqClr = '0;
  endtask

  task automatic startBurst(int len);
    burstLen = 8'(len); burstStart = 1; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1"; dmaEn = 1; txFill = 3; rxFill = 2; txTrig = 5; rxTrig = 1;
    irqMask = 4'hF;
    tick(); tick();
    rstN = 1; tick();

    // R2: load on start; start while active ignored
    curReq = "R2"; startBurst(5);
    burstLen = 9; burstStart = 1; tick();

    // R3: decrement per byte
    curReq = "R3"; byteDone = 1; tick(); byteDone = 1; tick();

    // R4: count to zero, then zero-length start
    curReq = "R4"; repeat (3) begin byteDone = 1; tick(); end
    byteDone = 1; tick();  // idle byte ignored
    startBurst(0); tick();

    // R5: data NACK with STOP requested
    curReq = "R5"; stopReq = 1; startBurst(6); byteDone = 1; tick();
    nackData = 1; byteDone = 1; tick(); tick();

    // R6: data NACK without STOP
    curReq = "R6"; stopReq = 0; startBurst(6); byteDone = 1; tick();
    nackData = 1; tick(); tick();

    // R7: address NACK, then NACK while idle
    curReq = "R7"; startBurst(4); nackAddr = 1; nackData = 1; tick(); tick();
    nackAddr = 1; tick(); nackData = 1; stopReq = 1; tick(); stopReq = 0;

    // R8/R9: sweep levels while count falls through 4
    curReq = "R8"; startBurst(7);
    for (int f = 0; f <= DEPTH; f++) begin txFill = 4'(f); rxFill = 4'(DEPTH - f); tick(); end
    curReq = "R9"; txTrig = 4; rxTrig = 4;
    for (int k = 0; k < 5; k++) begin
      for (int f = 3; f <= 5; f++) begin txFill = 4'(f); rxFill = 4'(f); tick(); end
      byteDone = 1; tick();
    end

    // R10: gating
    curReq = "R10"; startBurst(9); txFill = 0; rxFill = 5; dmaEn = 0; tick(); tick();
    dmaEn = 1; tick(); nackData = 1; tick(); tick();

    // R11: DMA done pulses, active and idle
    curReq = "R11"; dmaDoneTx = 1; tick(); dmaDoneRx = 1; tick();

    // R12: clear, mask, set wins
    curReq = "R12"; irqMask = 4'b0101; tick();
    irqClr = 4'b0011; tick(); tick();
    dmaDoneTx = 1; irqClr = 4'b0100; tick();
    irqClr = 4'hF; tick(); irqMask = 4'hF; tick();

    // mixed stimulus
    curReq = "R3";
    for (int n = 0; n < 600; n++) begin
      burstLen   = 8'($urandom_range(0, 12));
      burstStart = ($urandom_range(0, 7) == 0);
      byteDone   = ($urandom_range(0, 1) == 0);
      nackData   = ($urandom_range(0, 19) == 0);
      nackAddr   = ($urandom_range(0, 29) == 0);
      stopReq    = $urandom_range(0, 1) != 0;
      dmaEn      = ($urandom_range(0, 5) != 0);
      txFill = 4'($urandom_range(0, DEPTH)); rxFill = 4'($urandom_range(0, DEPTH));
      txTrig = 4'($urandom_range(0, DEPTH)); rxTrig = 4'($urandom_range(0, DEPTH));
      dmaDoneTx = ($urandom_range(0, 9) == 0); dmaDoneRx = ($urandom_range(0, 9) == 0);
      irqClr  = 4'($urandom_range(0, 15) & (($urandom_range(0, 3) == 0) ? 15 : 0));
      irqMask = 4'($urandom_range(0, 15));
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule